// File: doc/BRIEF.md
# Two-Channel Egress Arbiter with Buffer Lending

This block sits on one port of a packet switch. At ingress, it sorts each arriving packet into one of two virtual channels, a low-priority channel (VC0) and a high-priority channel (VC1). The sort uses the packet's 3-bit traffic class and a per-class selection register. At egress, it picks which channel's queue head goes out next. VC1 is served first, within a credit budget that refills once per fixed window. This keeps time-sensitive traffic unblocked without letting it take the whole link.

The block also sets how the port's packet storage is split between the two channels. When a port carries only best-effort traffic, software can enable lending. The VC1 storage is then handed to VC0 so that VC0 can absorb longer bursts. Lending changes only at a quiet point, when both queues are empty. While lending is active, any packet that would have gone to VC1 is flagged and placed in VC0.

Top module: `vc_egress_arb`

## Requirements
- R1: A packet of traffic class 0 is always placed in VC0 (`in_vc`=0), and its `in_bad_map` is 0, whatever bit 0 of `tc_map` holds.
- R2: While lending is inactive, a packet of traffic class n (1..7) goes to VC1 (`in_vc`=1) when `tc_map[n]`=1 and to VC0 when `tc_map[n]`=0, with `in_bad_map`=0.
- R3: While lending is active, a valid packet whose class selects VC1 gets `in_vc`=0 and `in_bad_map`=1. `in_bad_map` is 0 whenever `in_valid`=0.
- R4: At most one of `gnt_vc0` and `gnt_vc1` is high in any cycle. Neither is high while `eg_ready`=0. A grant is given only to a channel whose queue reports non-empty.
- R5: When `eg_ready`=1, the VC1 queue is non-empty and VC1 still has budget in the current window, `gnt_vc1`=1. `gnt_vc0` is high only when VC1 is not granted.
- R6: Windows are `WINDOW` cycles long and are counted from reset release. VC1 receives at most `vc1_budget` grants per window. Once the budget is used, a non-empty VC0 is granted for the rest of the window, and the budget refills at the start of the next window.
- R7: `reloc_active` takes the value of `reloc_req` at a clock edge only when both queues are empty. Otherwise it holds its value.
- R8: With lending inactive, `cap_vc0`=`VC0_DEPTH` and `cap_vc1`=`VC1_DEPTH`. With lending active, `cap_vc0`=`VC0_DEPTH+VC1_DEPTH` and `cap_vc1`=0.
- R9: After reset, `reloc_active`=0, the capacities are as for inactive lending, and a new window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An ingress packet is being classified |
| in_tc | input | 3 | Traffic class of the ingress packet |
| tc_map | input | 8 | Per-class channel select, 1 = VC1 (bit 0 ignored) |
| in_vc | output | 1 | Channel chosen for the ingress packet |
| in_bad_map | output | 1 | Class selects VC1 while lending is active |
| reloc_req | input | 1 | Requested lending state |
| q0_nonempty | input | 1 | VC0 egress queue holds a packet |
| q1_nonempty | input | 1 | VC1 egress queue holds a packet |
| eg_ready | input | 1 | Link can take a packet this cycle |
| vc1_budget | input | $clog2(WINDOW+1) | VC1 grants allowed per window |
| gnt_vc0 | output | 1 | Send VC0 queue head |
| gnt_vc1 | output | 1 | Send VC1 queue head |
| reloc_active | output | 1 | Lending currently in force |
| cap_vc0 | output | $clog2(VC0_DEPTH+VC1_DEPTH+1) | Storage granted to VC0 |
| cap_vc1 | output | $clog2(VC0_DEPTH+VC1_DEPTH+1) | Storage granted to VC1 |

## Verification
The bench sets bit 0 of the map to 1. A design that read that bit would send class 0 to VC1. It runs VC1 back to back across two windows, so an arbiter that miscounted the budget, refilled it late or gave VC1 unlimited priority would show the wrong grant in a given window cycle. It raises and drops the lending request while a queue is busy. A design that switched without waiting for a quiet point would move the capacities early. It also checks that a VC1-mapped class under lending is both flagged and steered. A design that only flagged it would leak packets into VC1, which then has no storage.

// File: rtl/vc_arb_pkg.sv
package vc_arb_pkg;
  localparam int unsigned NUM_TC = 8;
  localparam int unsigned TC_W   = $clog2(NUM_TC);

  typedef logic [TC_W-1:0]   tc_t;
  typedef logic [NUM_TC-1:0] tc_map_t;

  // Class 0 never asks for the high channel.
  function automatic logic tc_wants_high(tc_t tc, tc_map_t map);
    return (tc != '0) && map[tc];
  endfunction

  // Channel actually used: lending forces everything low.
  function automatic logic steer_vc(tc_t tc, tc_map_t map, logic lending);
    return tc_wants_high(tc, map) && !lending;
  endfunction

  function automatic logic map_conflict(logic valid, tc_t tc, tc_map_t map, logic lending);
    return valid && lending && tc_wants_high(tc, map);
  endfunction
endpackage

// File: rtl/vc_tc_mapper.sv
module vc_tc_mapper
  import vc_arb_pkg::*;
(
  input  logic              in_valid,
  input  logic [TC_W-1:0]   in_tc,
  input  logic [NUM_TC-1:0] tc_map,
  input  logic              lending,
  output logic              out_vc,
  output logic              bad_map
);
  always_comb begin
    out_vc  = steer_vc(in_tc, tc_map, lending);
    bad_map = map_conflict(in_valid, in_tc, tc_map, lending);
  end
endmodule

// File: rtl/vc_reloc_ctrl.sv
module vc_reloc_ctrl #(
  parameter int unsigned VC0_DEPTH = 16,
  parameter int unsigned VC1_DEPTH = 8,
  localparam int unsigned CAP_W = $clog2(VC0_DEPTH + VC1_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reloc_req,
  input  logic             q0_nonempty,
  input  logic             q1_nonempty,
  output logic             quiet,
  output logic             lending,
  output logic [CAP_W-1:0] cap0,
  output logic [CAP_W-1:0] cap1
);
  localparam logic [CAP_W-1:0] BASE0 = CAP_W'(VC0_DEPTH);
  localparam logic [CAP_W-1:0] BASE1 = CAP_W'(VC1_DEPTH);

  assign quiet = !q0_nonempty && !q1_nonempty;

  always_ff @(posedge clk) begin
    if (!rst_n)     lending <= 1'b0;
    else if (quiet) lending <= reloc_req;
  end

  always_comb begin
    if (lending) begin
      cap0 = BASE0 + BASE1;
      cap1 = '0;
    end else begin
      cap0 = BASE0;
      cap1 = BASE1;
    end
  end
endmodule

// File: rtl/vc_strict_arb.sv
module vc_strict_arb #(
  parameter int unsigned WINDOW = 16,
  localparam int unsigned WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1,
  localparam int unsigned BUD_W = $clog2(WINDOW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eg_ready,
  input  logic             q0_nonempty,
  input  logic             q1_nonempty,
  input  logic [BUD_W-1:0] vc1_budget,
  output logic             gnt0,
  output logic             gnt1,
  output logic             budget_left,
  output logic [BUD_W-1:0] vc1_used
);
  localparam logic [WIN_W-1:0] LAST = WIN_W'(WINDOW - 1);

  logic [WIN_W-1:0] win_cnt;
  logic             win_last;

  assign win_last    = (win_cnt == LAST);
  assign budget_left = (vc1_used < vc1_budget);
  assign gnt1        = eg_ready && q1_nonempty && budget_left;
  assign gnt0        = eg_ready && q0_nonempty && !gnt1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      vc1_used <= '0;
    end else if (win_last) begin
      win_cnt  <= '0;
      vc1_used <= '0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (gnt1) vc1_used <= vc1_used + 1'b1;
    end
  end
endmodule

// File: rtl/vc_egress_arb.sv
module vc_egress_arb
  import vc_arb_pkg::*;
#(
  parameter int unsigned VC0_DEPTH = 16,
  parameter int unsigned VC1_DEPTH = 8,
  parameter int unsigned WINDOW    = 16,
  localparam int unsigned CAP_W = $clog2(VC0_DEPTH + VC1_DEPTH + 1),
  localparam int unsigned BUD_W = $clog2(WINDOW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [TC_W-1:0]   in_tc,
  input  logic [NUM_TC-1:0] tc_map,
  output logic              in_vc,
  output logic              in_bad_map,
  input  logic              reloc_req,
  input  logic              q0_nonempty,
  input  logic              q1_nonempty,
  input  logic              eg_ready,
  input  logic [BUD_W-1:0]  vc1_budget,
  output logic              gnt_vc0,
  output logic              gnt_vc1,
  output logic              reloc_active,
  output logic [CAP_W-1:0]  cap_vc0,
  output logic [CAP_W-1:0]  cap_vc1
);
  logic             quiet;
  logic             budget_left;
  logic [BUD_W-1:0] vc1_used;

  vc_tc_mapper u_map (
    .in_valid (in_valid),
    .in_tc    (in_tc),
    .tc_map   (tc_map),
    .lending  (reloc_active),
    .out_vc   (in_vc),
    .bad_map  (in_bad_map)
  );

  vc_reloc_ctrl #(.VC0_DEPTH(VC0_DEPTH), .VC1_DEPTH(VC1_DEPTH)) u_reloc (
    .clk         (clk),
    .rst_n       (rst_n),
    .reloc_req   (reloc_req),
    .q0_nonempty (q0_nonempty),
    .q1_nonempty (q1_nonempty),
    .quiet       (quiet),
    .lending     (reloc_active),
    .cap0        (cap_vc0),
    .cap1        (cap_vc1)
  );

  vc_strict_arb #(.WINDOW(WINDOW)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .eg_ready    (eg_ready),
    .q0_nonempty (q0_nonempty),
    .q1_nonempty (q1_nonempty),
    .vc1_budget  (vc1_budget),
    .gnt0        (gnt_vc0),
    .gnt1        (gnt_vc1),
    .budget_left (budget_left),
    .vc1_used    (vc1_used)
  );
endmodule

// File: rtl/vc_egress_arb_chk.sv
module vc_egress_arb_chk #(
  parameter int unsigned VC0_DEPTH = 16,
  parameter int unsigned VC1_DEPTH = 8,
  parameter int unsigned CAP_W = 5,
  parameter int unsigned BUD_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [2:0]       in_tc,
  input logic             in_vc,
  input logic             in_bad_map,
  input logic             reloc_active,
  input logic             quiet,
  input logic             q0_nonempty,
  input logic             q1_nonempty,
  input logic             eg_ready,
  input logic             gnt_vc0,
  input logic             gnt_vc1,
  input logic             budget_left,
  input logic [BUD_W-1:0] vc1_used,
  input logic [BUD_W-1:0] vc1_budget,
  input logic [CAP_W-1:0] cap_vc0,
  input logic [CAP_W-1:0] cap_vc1
);
  p_tc0_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_tc == 3'd0) |-> (!in_vc && !in_bad_map));

  p_flag_steers_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_bad_map |-> (!in_vc && reloc_active));

  p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_vc0, gnt_vc1}));

  p_grant_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vc0 || gnt_vc1) |-> eg_ready);

  p_grant_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vc0 |-> q0_nonempty) and (gnt_vc1 |-> q1_nonempty));

  p_high_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eg_ready && q1_nonempty && budget_left) |-> gnt_vc1);

  p_budget_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vc1 |-> (vc1_used < vc1_budget));

  p_reloc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !quiet |=> (reloc_active == $past(reloc_active)));

  p_cap_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cap_vc0) + 32'(cap_vc1)) == (VC0_DEPTH + VC1_DEPTH));

  p_lend_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reloc_active |-> (cap_vc1 == '0));
endmodule

bind vc_egress_arb vc_egress_arb_chk #(
  .VC0_DEPTH(VC0_DEPTH), .VC1_DEPTH(VC1_DEPTH), .CAP_W(CAP_W), .BUD_W(BUD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tc(in_tc), .in_vc(in_vc),
  .in_bad_map(in_bad_map), .reloc_active(reloc_active), .quiet(quiet),
  .q0_nonempty(q0_nonempty), .q1_nonempty(q1_nonempty), .eg_ready(eg_ready),
  .gnt_vc0(gnt_vc0), .gnt_vc1(gnt_vc1), .budget_left(budget_left),
  .vc1_used(vc1_used), .vc1_budget(vc1_budget), .cap_vc0(cap_vc0), .cap_vc1(cap_vc1)
);

// File: tb/vc_egress_arb_bench.sv
module vc_egress_arb_bench;
  localparam int CLK_P = 10;
  localparam int D0 = 16;
  localparam int D1 = 8;
  localparam int WIN = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [2:0] in_tc;
  logic [7:0] tc_map;
  logic       in_vc, in_bad_map;
  logic       reloc_req, q0_nonempty, q1_nonempty, eg_ready;
  logic [4:0] vc1_budget;
  logic       gnt_vc0, gnt_vc1, reloc_active;
  logic [4:0] cap_vc0, cap_vc1;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  vc_egress_arb u_vc_egress_arb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tc(in_tc), .tc_map(tc_map),
    .in_vc(in_vc), .in_bad_map(in_bad_map), .reloc_req(reloc_req),
    .q0_nonempty(q0_nonempty), .q1_nonempty(q1_nonempty), .eg_ready(eg_ready),
    .vc1_budget(vc1_budget), .gnt_vc0(gnt_vc0), .gnt_vc1(gnt_vc1),
    .reloc_active(reloc_active), .cap_vc0(cap_vc0), .cap_vc1(cap_vc1)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reset with quiet inputs; returns in cycle 0 of the first window.
  task automatic do_reset();
    rst_n = 1'b0; in_valid = 0; in_tc = 0; tc_map = 0; reloc_req = 0;
    q0_nonempty = 0; q1_nonempty = 0; eg_ready = 0; vc1_budget = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    check("R9 reloc_active", int'(reloc_active), 0);
    check("R9 cap_vc0", int'(cap_vc0), D0);
    check("R9 cap_vc1", int'(cap_vc1), D1);
    check("R4 idle grants", int'({gnt_vc1, gnt_vc0}), 0);
  endtask

  task automatic t_mapping();
    do_reset();
    tc_map = 8'b1010_0101;   // bit 0 set on purpose: must be ignored
    in_valid = 1;
    for (int t = 0; t < 8; t++) begin
      in_tc = 3'(t);
      #1;
      if (t == 0) begin
        check("R1 tc0 vc", int'(in_vc), 0);
        check("R1 tc0 flag", int'(in_bad_map), 0);
      end else begin
        check("R2 tc vc", int'(in_vc), int'(tc_map[t]));
        check("R2 tc flag", int'(in_bad_map), 0);
      end
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic t_budget();
    do_reset();
    vc1_budget = 5'd3; q0_nonempty = 1; q1_nonempty = 1; eg_ready = 1;
    for (int i = 0; i < 2*WIN; i++) begin
      #1;
      check("R5/R6 gnt_vc1", int'(gnt_vc1), ((i % WIN) < 3) ? 1 : 0);
      check("R6 gnt_vc0", int'(gnt_vc0), ((i % WIN) < 3) ? 0 : 1);
      @(negedge clk);
    end
    eg_ready = 0;
    #1;
    check("R4 not ready", int'({gnt_vc1, gnt_vc0}), 0);
    @(negedge clk);
    eg_ready = 1; q1_nonempty = 0;
    #1;
    check("R4 only vc0 pending", int'({gnt_vc1, gnt_vc0}), 1);
    q0_nonempty = 0;
    #1;
    check("R4 nothing pending", int'({gnt_vc1, gnt_vc0}), 0);
    @(negedge clk);
  endtask

  task automatic t_lending();
    do_reset();
    tc_map = 8'b0100_0000;
    reloc_req = 1; q0_nonempty = 1;
    @(negedge clk); #1;
    check("R7 held while busy", int'(reloc_active), 0);
    check("R8 cap_vc1 unchanged", int'(cap_vc1), D1);
    q0_nonempty = 0;
    @(negedge clk); #1;
    check("R7 taken when quiet", int'(reloc_active), 1);
    check("R8 cap_vc0 lent", int'(cap_vc0), D0 + D1);
    check("R8 cap_vc1 zero", int'(cap_vc1), 0);
    in_valid = 1; in_tc = 3'd6;
    #1;
    check("R3 steered low", int'(in_vc), 0);
    check("R3 flagged", int'(in_bad_map), 1);
    in_tc = 3'd5;
    #1;
    check("R3 low class unflagged", int'(in_bad_map), 0);
    in_tc = 3'd6; in_valid = 0;
    #1;
    check("R3 no flag w/o valid", int'(in_bad_map), 0);
    reloc_req = 0; q1_nonempty = 1;
    @(negedge clk); #1;
    check("R7 hold on while busy", int'(reloc_active), 1);
    q1_nonempty = 0;
    @(negedge clk); #1;
    check("R7 released when quiet", int'(reloc_active), 0);
    check("R8 cap_vc1 restored", int'(cap_vc1), D1);
  endtask

  initial begin
    t_reset_state();
    t_mapping();
    t_budget();
    t_lending();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule